// File: doc/BRIEF.md
# Serial Peripheral Port with Status Flags

This block is an 8-bit serial peripheral port that can act as bus master or as a selected slave. A CPU reaches it through a small synchronous register bus with three registers: control, status and data. In master mode a write to the data register loads the shift register and starts a frame. The block then drives SCK and MOSI and samples MISO. In slave mode it shifts on an external SCK while selected.

Most of the logic covers the status flags. Completion, write collision, overrun and mode fault are each set by hardware. Each is cleared only by its own ordered sequence of register accesses. Software can also override the slave-select pin and switch off the serial data output.

Registers sit at address 0 (control), 1 (status) and 2 (data). Address 3 reads as zero. Read data is registered: it appears on `regRdata` in the cycle after the read strobe. SPI timing is mode 0. Data changes while SCK is low and is sampled on the rising edge of SCK, most significant bit first.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After reset the control and status registers read 00h, `irq` is 0, and `sckOe`, `mosiOe` and `misoOe` are 0.
- R2: In master mode (control bit 6 = enable, bit 5 = master) with the completion flag clear and no frame running, a data write sends the byte MSB first on MOSI and captures 8 MISO bits on SCK rising edges. The completion flag (status bit 7) sets after 16 SCK half periods.
- R3: In master mode the SCK half period is `2 << rate` system clocks, where rate is control bits 1:0.
- R4: A data-register read returns the receive buffer, which holds the last byte received and not the byte written for transmit.
- R5: The completion flag stays set until a status-register access (read or write) is followed by a data-register read or write. A data access with no status access before it does not clear the flag.
- R6: While the completion flag is set, a data write is ignored: no frame starts and no SCK edge appears.
- R7: A data write while a frame is in progress sets the write-collision flag (status bit 6) and leaves the frame in flight unchanged. The flag clears by the same sequence as R5.
- R8: If a frame ends while the completion flag is still set, the overrun flag (status bit 5) sets and the receive buffer keeps the older byte. A status read clears overrun.
- R9: In master mode an effective select of 0 sets the mode-fault flag (status bit 4) and clears control bits 6 and 5, which stops SCK drive. Mode fault clears only when a status access made while it is set is followed by a control write.
- R10: `irq` is 1 exactly when control bit 7 is 1 and at least one of completion, overrun or mode fault is set.
- R11: When status bit 1 is 1, the SS pin is ignored and status bit 0 serves as an active-low select.
- R12: When status bit 2 is 1, `mosiOe` (in master mode) and `misoOe` (in slave mode) stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register address: 0 control, 1 status, 2 data |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| sckIn | input | 1 | Serial clock from an external master |
| sckOut | output | 1 | Serial clock driven in master mode |
| sckOe | output | 1 | Output enable for sckOut |
| mosiIn | input | 1 | Serial data in while in slave mode |
| mosiOut | output | 1 | Serial data out while in master mode |
| mosiOe | output | 1 | Output enable for mosiOut |
| misoIn | input | 1 | Serial data in while in master mode |
| misoOut | output | 1 | Serial data out while in slave mode |
| misoOe | output | 1 | Output enable for misoOut |
| ssIn | input | 1 | Slave-select pin, active low |

## Verification
Register reads return one cycle after the strobe, so the bench takes read data at the next falling clock edge. A master frame ends 16 half periods after the clock edge that takes the data write, with each half period `2 << rate` cycles. The bench waits that long plus a small margin before it reads status. It also times the high phase of SCK against the exact expected count.

Slave inputs pass a two-stage synchronizer. The bench therefore holds each slave SCK phase for 8 cycles and waits 6 cycles after the last falling edge before it looks at the flags. Select and mode-fault effects are checked a few cycles after the pin changes, which covers the synchronizer delay.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } regAddr_e;

  // strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic load;     // copy write data into the shift register
    logic sample;   // capture the incoming serial bit
    logic shift;    // advance the shift register by one bit
    logic abort;    // drop a partial frame
    logic holdBuf;  // receive buffer must keep its unread byte
  } dpCtl_t;

  localparam logic [7:0] CTRL_MASK = 8'hE3;
  localparam logic [7:0] CFG_MASK  = 8'h07;

endpackage

// File: rtl/spi_flag_datapath.sv
module spi_flag_datapath
  import spi_flag_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic              serIn,
  output logic              serOut,
  output logic [DATA_W-1:0] rxBuf,
  output logic              frameEnd,
  output logic              midFrame
);

  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shiftQ;
  logic [DATA_W-1:0] bufQ;
  logic [CNT_W-1:0]  cntQ;
  logic              capQ;
  logic              inBitQ;
  logic [DATA_W-1:0] nextShift;

  assign nextShift = {shiftQ[DATA_W-2:0], capQ};
  assign frameEnd  = ctl.shift && (cntQ == LAST_BIT);
  assign midFrame  = (cntQ != '0) || inBitQ;
  assign serOut    = shiftQ[DATA_W-1];
  assign rxBuf     = bufQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      bufQ   <= '0;
      cntQ   <= '0;
      capQ   <= 1'b0;
      inBitQ <= 1'b0;
    end else begin
      if (ctl.abort) begin
        cntQ   <= '0;
        inBitQ <= 1'b0;
      end
      if (ctl.load) begin
        shiftQ <= wrData;
        cntQ   <= '0;
      end
      if (ctl.sample) begin
        capQ   <= serIn;
        inBitQ <= 1'b1;
      end
      if (ctl.shift) begin
        shiftQ <= nextShift;
        inBitQ <= 1'b0;
        cntQ   <= frameEnd ? '0 : cntQ + 1'b1;
        if (frameEnd && !ctl.holdBuf) bufQ <= nextShift;
      end
    end
  end

  // R8: an unread byte is never overwritten
  a_r8_buffer_kept: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && ctl.holdBuf) |=> $stable(bufQ));

  // R2: a frame only ends after a load or sample started it
  a_r2_frame_has_bits: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> inBitQ);

endmodule

// File: rtl/spi_flag_control.sv
module spi_flag_control
  import spi_flag_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned DIV_BASE    = 2,
  parameter int unsigned RATE_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              irq,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              misoIn,
  input  logic              ssIn,
  output logic              sckOut,
  output logic              sckOe,
  output logic              mosiOe,
  output logic              misoOe,
  output dpCtl_t            ctl,
  output logic              serIn,
  input  logic              frameEnd,
  input  logic              midFrame,
  input  logic [DATA_W-1:0] rxBuf
);

  localparam int unsigned HALF_MAX = DIV_BASE << ((1 << RATE_W) - 1);
  localparam int unsigned HC_W     = $clog2(HALF_MAX) + 1;

  regAddr_e addrE;
  assign addrE = regAddr_e'(regAddr);

  // pin synchronizers
  logic [SYNC_STAGES-1:0] sckSyn, mosiSyn, ssSyn;
  logic sckS, mosiS, ssS, sckPrevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSyn   <= '0;
      mosiSyn  <= '0;
      ssSyn    <= '1;
      sckPrevQ <= 1'b0;
    end else begin
      sckSyn   <= {sckSyn[SYNC_STAGES-2:0], sckIn};
      mosiSyn  <= {mosiSyn[SYNC_STAGES-2:0], mosiIn};
      ssSyn    <= {ssSyn[SYNC_STAGES-2:0], ssIn};
      sckPrevQ <= sckS;
    end
  end

  assign sckS  = sckSyn[SYNC_STAGES-1];
  assign mosiS = mosiSyn[SYNC_STAGES-1];
  assign ssS   = ssSyn[SYNC_STAGES-1];

  // registers and flags
  logic [7:0] ctrlQ, cfgQ;
  logic doneQ, wcolQ, ovrQ, modfQ;
  logic armDataQ, armModfQ;
  logic runQ, sckLvlQ;
  logic [HC_W-1:0] halfCntQ;
  logic [7:0] rdataQ;

  logic irqEn, blockEn, mstSel, outDis, selSw, selInt;
  logic [RATE_W-1:0] rate;
  assign irqEn   = ctrlQ[7];
  assign blockEn = ctrlQ[6];
  assign mstSel  = ctrlQ[5];
  assign rate    = ctrlQ[RATE_W-1:0];
  assign outDis  = cfgQ[2];
  assign selSw   = cfgQ[1];
  assign selInt  = cfgQ[0];

  logic selN, masterOn, slaveOn;
  logic statAcc, statRd, dataAcc, dataWr, ctrlWr;
  logic busyNow, faultEvt, wrAccept, collide, clearSeq;
  logic [HC_W-1:0] halfLim;
  logic halfHit, sckRise, sckFall;

  assign selN     = selSw ? selInt : ssS;
  assign masterOn = blockEn && mstSel;
  assign slaveOn  = blockEn && !mstSel && !selN;

  assign statAcc  = (regRd || regWr) && (addrE == REG_STAT);
  assign statRd   = regRd && (addrE == REG_STAT);
  assign dataAcc  = (regRd || regWr) && (addrE == REG_DATA);
  assign dataWr   = regWr && (addrE == REG_DATA);
  assign ctrlWr   = regWr && (addrE == REG_CTRL);

  assign busyNow  = runQ || midFrame;
  assign faultEvt = masterOn && !selN;
  assign wrAccept = dataWr && !doneQ && !busyNow;
  assign collide  = dataWr && busyNow;
  assign clearSeq = dataAcc && armDataQ;

  assign halfLim  = HC_W'(DIV_BASE) << rate;
  assign halfHit  = runQ && (halfCntQ == halfLim - 1'b1);
  assign sckRise  = slaveOn && sckS && !sckPrevQ;
  assign sckFall  = slaveOn && !sckS && sckPrevQ;

  always_comb begin
    ctl.load    = wrAccept;
    ctl.sample  = (halfHit && !sckLvlQ) || sckRise;
    ctl.shift   = (halfHit && sckLvlQ) || sckFall;
    ctl.abort   = faultEvt || (!masterOn && !slaveOn);
    ctl.holdBuf = doneQ;
  end

  assign serIn  = masterOn ? misoIn : mosiS;
  assign sckOut = sckLvlQ;
  assign sckOe  = masterOn;
  assign mosiOe = masterOn && !outDis;
  assign misoOe = slaveOn && !outDis;
  assign irq    = irqEn && (doneQ || ovrQ || modfQ);

  // master clock generation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      sckLvlQ  <= 1'b0;
      halfCntQ <= '0;
    end else if (faultEvt) begin
      runQ     <= 1'b0;
      sckLvlQ  <= 1'b0;
      halfCntQ <= '0;
    end else if (wrAccept && masterOn) begin
      runQ     <= 1'b1;
      sckLvlQ  <= 1'b0;
      halfCntQ <= '0;
    end else if (runQ) begin
      if (halfHit) begin
        halfCntQ <= '0;
        sckLvlQ  <= !sckLvlQ;
        if (frameEnd) runQ <= 1'b0;
      end else begin
        halfCntQ <= halfCntQ + 1'b1;
      end
    end
  end

  // register file and status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      cfgQ     <= '0;
      doneQ    <= 1'b0;
      wcolQ    <= 1'b0;
      ovrQ     <= 1'b0;
      modfQ    <= 1'b0;
      armDataQ <= 1'b0;
      armModfQ <= 1'b0;
    end else begin
      if (ctrlWr) ctrlQ <= regWdata & CTRL_MASK;
      if (faultEvt) ctrlQ[6:5] <= 2'b00;
      if (regWr && addrE == REG_STAT) cfgQ <= regWdata & CFG_MASK;

      if (frameEnd) doneQ <= 1'b1;
      else if (clearSeq) doneQ <= 1'b0;

      if (collide) wcolQ <= 1'b1;
      else if (clearSeq) wcolQ <= 1'b0;

      if (statAcc) armDataQ <= 1'b1;
      else if (dataAcc) armDataQ <= 1'b0;

      if (frameEnd && doneQ) ovrQ <= 1'b1;
      else if (statRd) ovrQ <= 1'b0;

      if (faultEvt) modfQ <= 1'b1;
      else if (ctrlWr && armModfQ) modfQ <= 1'b0;

      if (statAcc && modfQ) armModfQ <= 1'b1;
      else if (ctrlWr) armModfQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (regRd) begin
      unique case (addrE)
        REG_CTRL: rdataQ <= ctrlQ;
        REG_STAT: rdataQ <= {doneQ, wcolQ, ovrQ, modfQ, 1'b0, cfgQ[2:0]};
        REG_DATA: rdataQ <= rxBuf;
        default:  rdataQ <= '0;
      endcase
    end
  end
  assign regRdata = rdataQ;

  // R5: completion holds until a data access arrives
  a_r5_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !dataAcc) |=> doneQ);

  // R7: a collision only arises while a frame was under way
  a_r7_wcol_in_transfer: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wcolQ) |-> $past(runQ || midFrame));

  // R9: a fresh mode fault leaves master mode switched off
  a_r9_fault_drops_master: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modfQ) |-> !sckOe);

  // R10: interrupt never rises without its enable
  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ctrlQ[7]);

  // R12: disabled output stays undriven
  a_r12_outputs_off: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ[2] |-> !(mosiOe || misoOe));

endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned DIV_BASE    = 2,
  parameter int unsigned RATE_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regAddr,
  input  logic        regRd,
  input  logic        regWr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  output logic        irq,
  input  logic        sckIn,
  output logic        sckOut,
  output logic        sckOe,
  input  logic        mosiIn,
  output logic        mosiOut,
  output logic        mosiOe,
  input  logic        misoIn,
  output logic        misoOut,
  output logic        misoOe,
  input  logic        ssIn
);

  dpCtl_t            ctl;
  logic              serIn, serOut, frameEnd, midFrame;
  logic [DATA_W-1:0] rxBuf;

  spi_flag_control #(
    .DATA_W(DATA_W), .DIV_BASE(DIV_BASE), .RATE_W(RATE_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_control (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regRd(regRd), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq),
    .sckIn(sckIn), .mosiIn(mosiIn), .misoIn(misoIn), .ssIn(ssIn),
    .sckOut(sckOut), .sckOe(sckOe), .mosiOe(mosiOe), .misoOe(misoOe),
    .ctl(ctl), .serIn(serIn), .frameEnd(frameEnd), .midFrame(midFrame),
    .rxBuf(rxBuf)
  );

  spi_flag_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(regWdata[DATA_W-1:0]),
    .serIn(serIn), .serOut(serOut), .rxBuf(rxBuf),
    .frameEnd(frameEnd), .midFrame(midFrame)
  );

  assign mosiOut = serOut;
  assign misoOut = serOut;

endmodule

// File: tb/spi_flag_ctrl_tb.sv
module spi_flag_ctrl_tb;

  localparam int CLK_P = 10;
  localparam int SH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic regRd = 1'b0, regWr = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic irq, sckOut, sckOe, mosiOut, mosiOe, misoOut, misoOe;
  logic sckIn = 1'b0, mosiIn = 1'b0, ssIn = 1'b1;
  logic misoIn;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_flag_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRd(regRd), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq),
    .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe),
    .mosiIn(mosiIn), .mosiOut(mosiOut), .mosiOe(mosiOe),
    .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe), .ssIn(ssIn)
  );

  // bench model of the far-end slave
  logic [7:0] slvByte = '0;
  logic [7:0] gotMosi;
  logic [3:0] bitIdx;
  int edgeCnt;
  logic mdlClr = 1'b0;
  int cyc = 0, riseAt = 0, highLen = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge sckOut or posedge mdlClr)
    if (mdlClr) begin gotMosi <= '0; edgeCnt <= 0; end
    else begin gotMosi <= {gotMosi[6:0], mosiOut}; edgeCnt <= edgeCnt + 1; riseAt <= cyc; end
  always @(negedge sckOut or posedge mdlClr)
    if (mdlClr) bitIdx <= '0;
    else begin bitIdx <= bitIdx + 1'b1; highLen <= cyc - riseAt; end
  assign misoIn = (bitIdx < 4'd8) ? slvByte[3'd7 - bitIdx[2:0]] : 1'b0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rreg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRd = 1'b1;
    @(negedge clk); regRd = 1'b0; d = regRdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int halfOf(int r);
    return 2 << r;
  endfunction

  function automatic logic [7:0] statOf(bit d, bit w, bit o, bit m, logic [2:0] cfg);
    return {d, w, o, m, 1'b0, cfg};
  endfunction

  task automatic clrMdl();
    @(negedge clk); mdlClr = 1'b1; @(negedge clk); mdlClr = 1'b0;
  endtask

  // slave-side frame driven by the bench as external master
  task automatic sframe(logic [7:0] tx, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      mosiIn = tx[i]; idle(SH);
      sckIn = 1'b1; got[i] = misoOut; idle(SH);
      sckIn = 1'b0;
    end
    idle(6);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d, g;
    int r;
    void'($urandom(32'h5A17));
    idle(3); clrMdl();
    // R1 reset state
    rreg(2'd0, d); chk("R1 ctrl", d, 8'h00);
    rreg(2'd1, d); chk("R1 stat", d, 8'h00);
    chk("R1 irq", irq, 0); chk("R1 oe", {sckOe, mosiOe, misoOe}, 0);
    rstN = 1'b1; idle(2);
    rreg(2'd0, d); chk("R1 ctrl after release", d, 8'h00);
    rreg(2'd1, d); chk("R1 stat after release", d, 8'h00);

    // random master frames: R2 R3 R4 R5
    for (int k = 0; k < 24; k++) begin
      logic [7:0] tx, rx;
      tx = 8'($urandom); rx = 8'($urandom); r = $urandom_range(0, 3);
      slvByte = rx; clrMdl();
      wreg(2'd0, 8'h60 | 8'(r));
      wreg(2'd2, tx);
      idle(16 * halfOf(r) + 4);
      chk("R2 mosi bits", gotMosi, tx);
      chk("R2 edge count", edgeCnt, 8);
      chk("R3 sck half period", highLen, halfOf(r));
      rreg(2'd2, d); chk("R4 data read before arm", d, rx);
      rreg(2'd1, d); chk("R5 done still set", d, statOf(1, 0, 0, 0, 3'b000));
      rreg(2'd2, d); chk("R4 rx buffer", d, rx);
      rreg(2'd1, d); chk("R5 done cleared", d, 8'h00);
    end

    // R6 write ignored while done; R10 interrupt
    slvByte = 8'h3E; clrMdl();
    wreg(2'd0, 8'hE0); wreg(2'd2, 8'h81); idle(16 * 2 + 4);
    chk("R10 irq with done", irq, 1);
    clrMdl();
    wreg(2'd2, 8'h55); idle(40);
    chk("R6 no sck edges", edgeCnt, 0);
    wreg(2'd0, 8'h60);
    chk("R10 irq masked", irq, 0);
    rreg(2'd1, d); chk("R6 no collision", d, statOf(1, 0, 0, 0, 3'b000));
    rreg(2'd2, d); chk("R4 buffer kept", d, 8'h3E);

    // R7 write collision
    slvByte = 8'h00; clrMdl();
    wreg(2'd2, 8'hA5); idle(10);
    wreg(2'd2, 8'h3C); idle(16 * 2 + 4);
    chk("R7 frame unchanged", gotMosi, 8'hA5);
    rreg(2'd1, d); chk("R7 wcol set", d, statOf(1, 1, 0, 0, 3'b000));
    rreg(2'd2, d);
    rreg(2'd1, d); chk("R7 wcol cleared", d, 8'h00);

    // R12 output disable in master mode
    wreg(2'd1, 8'h04); clrMdl(); wreg(2'd2, 8'h0F); idle(6);
    chk("R12 mosiOe off", mosiOe, 0); chk("R12 sckOe on", sckOe, 1);
    idle(40); rreg(2'd1, d); rreg(2'd2, d); wreg(2'd1, 8'h00);

    // R11 software select in master: pin low ignored
    wreg(2'd1, 8'h03); ssIn = 1'b0; idle(5);
    rreg(2'd1, d); chk("R11 no fault with sw select", d, 8'h03);
    wreg(2'd1, 8'h00); idle(1);
    // R9 mode fault from the pin
    idle(5); chk("R9 sckOe dropped", sckOe, 0);
    rreg(2'd0, d); chk("R9 ctrl cleared", d, 8'h00);
    ssIn = 1'b1;
    wreg(2'd0, 8'h00);
    rreg(2'd1, d); chk("R9 ctrl write alone keeps fault", d, statOf(0, 0, 0, 1, 3'b000));
    wreg(2'd0, 8'h00);
    rreg(2'd1, d); chk("R9 fault cleared", d, 8'h00);

    // R8 overrun in slave mode with pin select
    wreg(2'd0, 8'h40); ssIn = 1'b0; idle(4);
    wreg(2'd2, 8'hC3); idle(2);
    chk("R12 misoOe on", misoOe, 1);
    sframe(8'h5A, g);
    chk("R2 slave miso", g, 8'hC3);
    sframe(8'h96, g);
    rreg(2'd1, d); chk("R8 overrun set", d, statOf(1, 0, 1, 0, 3'b000));
    rreg(2'd1, d); chk("R8 overrun cleared by read", d, statOf(1, 0, 0, 0, 3'b000));
    rreg(2'd2, d); chk("R8 buffer holds first", d, 8'h5A);
    ssIn = 1'b1; idle(4);

    // R11 software select in slave mode, pin high; R12 misoOe off
    wreg(2'd1, 8'h06); idle(4);
    chk("R12 misoOe disabled", misoOe, 0);
    wreg(2'd1, 8'h02); idle(4);
    chk("R11 selected by internal bit", misoOe, 1);
    sframe(8'h71, g);
    rreg(2'd1, d); chk("R11 frame done", d, statOf(1, 0, 0, 0, 3'b010));
    rreg(2'd2, d); chk("R11 received", d, 8'h71);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule